// File: doc/BRIEF.md
# Skewed dual-converter trigger generator

This block issues the start commands for two sampling engines that share one clock. An arm request launches a single pulse on an internal line. The first engine's start trigger is taken from the pulse's leading edge and the second engine's from its trailing edge. The pulse width therefore is the time offset between the two engines. Both engines run from the same clock, so once started they keep that offset for as long as they run.

The width is held in a configuration register in whole microseconds, from 1 to 1000. A prescaler divides the system clock (36 MHz by default, so a divide of 36) into a 1 µs tick. The width counter counts that tick while the pulse is high. The register may be rewritten only while the block is stopped. The intended order is: stop, write the new width, enable, arm. A write made while enabled is dropped and latches an error flag. A copy of the internal pulse can be brought out on an observation pin for debugging. The triggers themselves are internal single-cycle strobes.

All pins are plain control and status signals. No data passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `skew_trig_gen`

## Requirements
- R1: After reset, trig_lead, trig_lag, pulse_obs and cfg_err are 0, and the width register holds 1 µs. An arm with no prior write gives a lead-to-lag spacing of TICK_DIV (36) cycles.
- R2: An arm sampled high while run_en is 1 and no pulse is active starts a pulse that stays high for exactly width × TICK_DIV clock cycles. pulse_obs shows that pulse when OBS_EN is 1.
- R3: trig_lead is high for exactly one clock cycle. It rises one cycle after the pulse rises.
- R4: trig_lag is high for exactly one clock cycle, one cycle after the pulse falls. It lands width × TICK_DIV cycles after trig_lead and never in the same cycle as trig_lead.
- R5: One-shot behaviour. One arm gives exactly one lead/lag pair. An arm sampled while the pulse is high is ignored, and no further pulse follows without a new arm.
- R6: An arm sampled while run_en is 0 starts no pulse and gives no trigger.
- R7: A cfg_we write with run_en at 0 loads cfg_width_us. A value of 0 is stored as 1, and a value above 1000 is stored as 1000.
- R8: A cfg_we write with run_en at 1 leaves the width unchanged and sets cfg_err. cfg_err stays at 1 until reset.
- R9: Dropping run_en while the pulse is high ends the pulse at the next clock edge, and no trig_lag is produced for that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = running (arm accepted, width locked); 0 = stopped |
| arm | input | 1 | Request one skew pulse |
| cfg_we | input | 1 | Width register write strobe |
| cfg_width_us | input | WIDTH_W | Width value in microseconds |
| trig_lead | output | 1 | Start strobe for the first engine (leading edge) |
| trig_lag | output | 1 | Start strobe for the second engine (trailing edge) |
| pulse_obs | output | 1 | Debug copy of the internal pulse (0 when OBS_EN = 0) |
| cfg_err | output | 1 | Sticky flag: width write attempted while running |

## Verification
The bench targets the extremes of the width range:
- The one-microsecond width: an off-by-one in the prescaler or the counter would show up as a spacing of 35 or 72 cycles.
- The clamped write values 0 and 1023: a missing clamp would give a zero-length or wrap-around pulse.
- An arm during an active pulse and a held arm: a design that retriggers would emit a second lead strobe.

The stop path gets three checks:
- Stopping mid-pulse must not leak a trailing strobe, which a plain falling-edge detector would produce.
- A write while running must neither change the spacing of the next shot nor leave the error flag cleared.
- The error flag must survive a stop, and only reset may clear it.

// File: rtl/skew_pkg.sv
package skew_pkg;
  localparam int DEF_TICK_DIV = 36;
  localparam int DEF_MAX_US   = 1000;
  localparam int DEF_WIDTH_W  = 10;

  typedef enum logic {
    SHOT_IDLE   = 1'b0,
    SHOT_ACTIVE = 1'b1
  } shot_e;
endpackage

// File: rtl/skew_width_cfg.sv
module skew_width_cfg #(
  parameter int WIDTH_W = skew_pkg::DEF_WIDTH_W,
  parameter int MAX_US  = skew_pkg::DEF_MAX_US
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               cfg_we,
  input  logic [WIDTH_W-1:0] cfg_width_us,
  output logic [WIDTH_W-1:0] width_q,
  output logic               err_q
);
  localparam logic [WIDTH_W-1:0] W_MIN = WIDTH_W'(1);
  localparam logic [WIDTH_W-1:0] W_MAX = WIDTH_W'(MAX_US);

  logic [WIDTH_W-1:0] width_clamped;

  always_comb begin
    if (cfg_width_us == '0)          width_clamped = W_MIN;
    else if (cfg_width_us > W_MAX)   width_clamped = W_MAX;
    else                             width_clamped = cfg_width_us;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= W_MIN;
      err_q   <= 1'b0;
    end else if (cfg_we) begin
      if (run_en) err_q   <= 1'b1;
      else        width_q <= width_clamped;
    end
  end

  // R8: register locked while running
  assert_width_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(width_q));
  // R8: error flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7: stored width always inside the legal range
  assert_width_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q >= W_MIN) && (width_q <= W_MAX));
endmodule

// File: rtl/skew_prescaler.sv
module skew_prescaler #(
  parameter int TICK_DIV = skew_pkg::DEF_TICK_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pre_q <= '0;
    else if (restart || !active)      pre_q <= '0;
    else if (pre_q == LAST)           pre_q <= '0;
    else                              pre_q <= pre_q + PW'(1);
  end

  assign tick = active && (pre_q == LAST);

  // R2: prescaler parked while no pulse is running
  assert_pre_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (pre_q == '0));
endmodule

// File: rtl/skew_oneshot.sv
module skew_oneshot #(
  parameter int WIDTH_W = skew_pkg::DEF_WIDTH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               tick,
  input  logic [WIDTH_W-1:0] width,
  output logic               pulse
);
  import skew_pkg::*;

  shot_e              st_q;
  logic [WIDTH_W-1:0] us_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SHOT_IDLE;
      us_left_q <= '0;
    end else if (abort) begin
      st_q      <= SHOT_IDLE;
      us_left_q <= '0;
    end else if (st_q == SHOT_IDLE) begin
      if (start) begin
        st_q      <= SHOT_ACTIVE;
        us_left_q <= width;
      end
    end else if (tick) begin
      us_left_q <= us_left_q - WIDTH_W'(1);
      if (us_left_q == WIDTH_W'(1)) st_q <= SHOT_IDLE;
    end
  end

  assign pulse = (st_q == SHOT_ACTIVE);

  // R2: accepted arm raises the pulse on the next edge
  assert_start_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !pulse) |=> pulse);
  // R9: stop ends the pulse immediately
  assert_abort_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !pulse);
  // R5: an active pulse never holds a zero count
  assert_count_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (us_left_q != '0));
endmodule

// File: rtl/skew_edge_trig.sv
module skew_edge_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  input  logic abort,
  output logic trig_lead,
  output logic trig_lag
);
  logic pulse_d_q;
  logic abort_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_d_q <= 1'b0;
      abort_d_q <= 1'b0;
      trig_lead <= 1'b0;
      trig_lag  <= 1'b0;
    end else begin
      pulse_d_q <= pulse;
      abort_d_q <= abort;
      trig_lead <= pulse && !pulse_d_q;
      trig_lag  <= !pulse && pulse_d_q && !abort_d_q;
    end
  end

  // R3: leading strobe lasts one cycle
  assert_lead_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_lead |=> !trig_lead);
  // R4: trailing strobe lasts one cycle
  assert_lag_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_lag |=> !trig_lag);
  // R4: the two strobes never coincide
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_lead && trig_lag));
  // R9: an aborted pulse yields no trailing strobe
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ##1 !trig_lag);
endmodule

// File: rtl/skew_trig_gen.sv
module skew_trig_gen #(
  parameter int TICK_DIV = skew_pkg::DEF_TICK_DIV,
  parameter int MAX_US   = skew_pkg::DEF_MAX_US,
  parameter int WIDTH_W  = skew_pkg::DEF_WIDTH_W,
  parameter bit OBS_EN   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               arm,
  input  logic               cfg_we,
  input  logic [WIDTH_W-1:0] cfg_width_us,
  output logic               trig_lead,
  output logic               trig_lag,
  output logic               pulse_obs,
  output logic               cfg_err
);
  logic [WIDTH_W-1:0] width_q;
  logic               pulse;
  logic               tick;
  logic               start;
  logic               abort;

  assign start = arm && run_en && !pulse;
  assign abort = pulse && !run_en;

  skew_width_cfg #(.WIDTH_W(WIDTH_W), .MAX_US(MAX_US)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
    .cfg_width_us(cfg_width_us), .width_q(width_q), .err_q(cfg_err)
  );

  skew_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .active(pulse), .restart(start), .tick(tick)
  );

  skew_oneshot #(.WIDTH_W(WIDTH_W)) u_shot (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .tick(tick), .width(width_q), .pulse(pulse)
  );

  skew_edge_trig u_edge (
    .clk(clk), .rst_n(rst_n), .pulse(pulse), .abort(abort),
    .trig_lead(trig_lead), .trig_lag(trig_lag)
  );

  generate
    if (OBS_EN) begin : g_obs
      assign pulse_obs = pulse;
    end else begin : g_no_obs
      assign pulse_obs = 1'b0;
    end
  endgenerate

  // R6: nothing starts while stopped
  assert_stopped_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !pulse) |=> !pulse);
endmodule

// File: tb/sim_skew_trig_gen.sv
module sim_skew_trig_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 36;
  localparam int MAXU = 1000;
  localparam int WW   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic arm = 1'b0;
  logic cfg_we = 1'b0;
  logic [WW-1:0] cfg_width_us = '0;
  logic trig_lead, trig_lag, pulse_obs, cfg_err;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_lead = 0, n_lag = 0, lead_at = 0, lag_at = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_trig_gen #(.TICK_DIV(TICK), .MAX_US(MAXU), .WIDTH_W(WW), .OBS_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .arm(arm), .cfg_we(cfg_we),
    .cfg_width_us(cfg_width_us), .trig_lead(trig_lead), .trig_lag(trig_lag),
    .pulse_obs(pulse_obs), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: remaining-cycle count and pending strobes
  bit m_pulse, m_lead, m_lag, lead_pend, lag_pend, m_err;
  int m_rem, m_width;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pulse = 0; m_lead = 0; m_lag = 0; lead_pend = 0; lag_pend = 0;
      m_err = 0; m_rem = 0; m_width = 1;
    end else begin
      m_lead = lead_pend; m_lag = lag_pend;
      lead_pend = 0; lag_pend = 0;
      if (cfg_we) begin
        if (run_en) m_err = 1;
        else if (cfg_width_us == 0) m_width = 1;
        else if (int'(cfg_width_us) > MAXU) m_width = MAXU;
        else m_width = int'(cfg_width_us);
      end
      if (m_pulse && !run_en) m_pulse = 0;
      else if (m_pulse) begin
        m_rem--;
        if (m_rem == 0) begin m_pulse = 0; lag_pend = 1; end
      end else if (arm && run_en) begin
        m_pulse = 1; m_rem = m_width * TICK; lead_pend = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(trig_lead == m_lead, "R3", "trig_lead vs model", trig_lead, m_lead);
      chk(trig_lag == m_lag, "R4", "trig_lag vs model", trig_lag, m_lag);
      chk(pulse_obs == m_pulse, "R2", "pulse_obs vs model", pulse_obs, m_pulse);
      chk(cfg_err == m_err, "R8", "cfg_err vs model", cfg_err, m_err);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && trig_lead) begin n_lead <= n_lead + 1; lead_at <= cyc; end
    if (rst_n && trig_lag)  begin n_lag <= n_lag + 1;  lag_at <= cyc; end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_w(input int v);
    @(negedge clk); cfg_we = 1'b1; cfg_width_us = WW'(v);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic fire(input int width_us, input string req);
    int l0, g0;
    l0 = n_lead; g0 = n_lag;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    wait_cyc(width_us * TICK + 8);
    chk(n_lead == l0 + 1, req, "one lead strobe", n_lead - l0, 1);
    chk(n_lag == g0 + 1, req, "one lag strobe", n_lag - g0, 1);
    chk(lag_at - lead_at == width_us * TICK, req, "lead-to-lag spacing",
        lag_at - lead_at, width_us * TICK);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int l0, g0;
    wait_cyc(4);
    chk(trig_lead == 0 && trig_lag == 0, "R1", "strobes in reset", trig_lead | trig_lag, 0);
    chk(pulse_obs == 0 && cfg_err == 0, "R1", "obs/err in reset", pulse_obs | cfg_err, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    run_en = 1'b1;
    fire(1, "R1");                       // default width 1 us

    // R5: re-arm during pulse ignored, held arm not repeated beyond its samples
    write_w(5);                          // enabled -> ignored, R8 err
    chk(cfg_err == 1, "R8", "error set by write while running", cfg_err, 1);
    l0 = n_lead;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    wait_cyc(10);
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    wait_cyc(TICK + 20);
    chk(n_lead == l0 + 1, "R5", "arm during pulse ignored", n_lead - l0, 1);
    chk(lag_at - lead_at == TICK, "R8", "width unchanged by locked write",
        lag_at - lead_at, TICK);
    wait_cyc(100);
    chk(n_lead == l0 + 1, "R5", "no repeat without arm", n_lead - l0, 1);

    // R6: arm while stopped
    run_en = 1'b0;
    l0 = n_lead;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    wait_cyc(80);
    chk(n_lead == l0, "R6", "arm while stopped", n_lead - l0, 0);
    chk(cfg_err == 1, "R8", "error persists after stop", cfg_err, 1);

    // R7: writes while stopped, including clamps
    write_w(3);   run_en = 1'b1; fire(3, "R7");   run_en = 1'b0;
    write_w(0);   run_en = 1'b1; fire(1, "R7");   run_en = 1'b0;
    write_w(17);  run_en = 1'b1; fire(17, "R2");  run_en = 1'b0;
    write_w(1023); run_en = 1'b1; fire(MAXU, "R7"); run_en = 1'b0;

    // R9: stop mid-pulse
    write_w(10);
    run_en = 1'b1;
    g0 = n_lag;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    wait_cyc(50);
    run_en = 1'b0;
    wait_cyc(2);
    chk(pulse_obs == 0, "R9", "pulse ends on stop", pulse_obs, 0);
    wait_cyc(500);
    chk(n_lag == g0, "R9", "no lag strobe after stop", n_lag - g0, 0);

    // R8: only reset clears the error flag
    rst_n = 1'b0;
    wait_cyc(2);
    chk(cfg_err == 0, "R8", "reset clears error", cfg_err, 0);
    rst_n = 1'b1;
    wait_cyc(4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule